// File: doc/BRIEF.md
# Ring Event Aggregator with Clear-on-Read Status

This block gathers completion and overflow events from a parameterised number of DMA rings (hops) and presents them to software as packed 32-bit status words. Three single-cycle pulse inputs per hop report transmit completion, receive completion and receive overflow. Each pulse latches a sticky status bit. Software reads a status word, and the same read clears that word.

A set of enable words selects which rings may raise the single interrupt output. After the interrupt fires, the block stays disarmed until software has read every status word, including words that only hold bits for disabled rings. A read-only identification word reports the hop count. Register access uses a simple 32-bit port: a read strobe returns data one cycle later, and a write strobe takes effect at the clock edge.

Top module: `ring_evt_agg`

## Requirements
- R1: A pulse on hop h sets status bit index k, where k = h for transmit, N+h for receive and 2N+h for receive overflow. Bit k sits in status word k/32 at bit k%32. Status word w is read at address w, and `rdata_o` shows the value in the cycle after the read strobe.
- R2: Reading a status word clears it, so an immediate second read of that word returns zero if no new event has arrived.
- R3: An event pulse in the same cycle as the read that clears its word is kept. That read returns the older contents, and the next read shows the new bit.
- R4: Enable word e sits at address 2^(ADDR_W-2)+e. Within the enable bits, index h is the receive enable for hop h and index N+h is the transmit enable for hop h. Writes store the bits and reads return them. Bits at index 2N and above always read as zero.
- R5: Address 2^ADDR_W-1 returns N in bits 10:0 and zero above, and writes to it have no effect. Addresses that are not mapped read as zero.
- R6: While armed, a set status bit whose enable bit is set raises `irq_o` for exactly one cycle, in the cycle after the bit is latched. This disarms the block.
- R7: Status bits whose enable bit is clear still latch but never raise `irq_o`.
- R8: Overflow bits always latch. They raise `irq_o` only when the receive enable bit of that hop is set.
- R9: After `irq_o` fires, no further interrupt is raised until every status word has been read at least once. Once the last unread word is read, the block re-arms, and any pending enabled bit fires `irq_o` in the following cycle.
- R10: After reset, all status and enable bits are zero, `irq_o` is low and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done_i | input | N | Transmit-complete pulse per hop |
| rx_done_i | input | N | Receive-complete pulse per hop |
| rx_ovf_i | input | N | Receive-overflow pulse per hop |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach is a disarmed block that holds a pending enabled event while only part of the read sweep is done. That state shows whether the interrupt waits for the last word, including a word that covers only disabled rings. The bench fires an interrupt and then reads only the first status word. It raises the enabled event again, confirms that no interrupt follows, and then reads the remaining overflow-only word to see the delayed interrupt appear. A separate case places an event pulse on the exact cycle of a clearing read.

// File: rtl/ring_evt_pkg.sv
package ring_evt_pkg;
   localparam int WORD_W = 32;

   // number of 32-bit words needed to hold a bit count
   function automatic int words_for(input int bits);
      return (bits + WORD_W - 1) / WORD_W;
   endfunction

   // index width for a count of words (at least one bit)
   function automatic int idx_width(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

   // mask of the valid bits inside word w of a field of the given length
   function automatic logic [WORD_W-1:0] valid_mask(input int bits, input int w);
      int cnt;
      cnt = bits - w * WORD_W;
      if (cnt >= WORD_W) return '1;
      if (cnt <= 0) return '0;
      return (WORD_W'(1) << cnt) - WORD_W'(1);
   endfunction
endpackage

// File: rtl/ring_evt_store.sv
module ring_evt_store #(
   parameter int N      = 12,
   parameter int SW     = 2,
   parameter int IDX_W  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         tx_ev,
   input  logic [N-1:0]         rx_ev,
   input  logic [N-1:0]         ovf_ev,
   input  logic                 clr_en,
   input  logic [IDX_W-1:0]     clr_idx,
   output logic [SW*32-1:0]     stat_flat
);
   logic [SW*32-1:0] ev_pad;
   logic [31:0]      st_q [SW];

   // pack events: transmit, then receive, then overflow
   always_comb begin
      ev_pad = '0;
      ev_pad[3*N-1:0] = {ovf_ev, rx_ev, tx_ev};
   end

   for (genvar w = 0; w < SW; w++) begin : g_word
      logic clr_hit;
      assign clr_hit = clr_en && (clr_idx == IDX_W'(w));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[w] <= '0;
         end else begin
            // clearing read and new event in one cycle: event survives
            st_q[w] <= (clr_hit ? 32'h0 : st_q[w]) | ev_pad[w*32 +: 32];
         end
      end

      assign stat_flat[w*32 +: 32] = st_q[w];
   end
endmodule

// File: rtl/ring_evt_mask.sv
module ring_evt_mask #(
   parameter int N     = 12,
   parameter int EW    = 1,
   parameter int IDX_W = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [31:0]        wdata,
   output logic [EW*32-1:0]   en_flat
);
   logic [31:0] en_q [EW];

   for (genvar w = 0; w < EW; w++) begin : g_word
      localparam logic [31:0] KEEP = ring_evt_pkg::valid_mask(2*N, w);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[w] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(w))) begin
            en_q[w] <= wdata;
         end
      end

      // bits beyond the 2N enables are forced to zero
      assign en_flat[w*32 +: 32] = en_q[w] & KEEP;
   end
endmodule

// File: rtl/ring_evt_arm.sv
module ring_evt_arm #(
   parameter int SW    = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stat,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             pending,
   output logic             irq
);
   logic [SW-1:0] seen_q;
   logic [SW-1:0] seen_nxt;
   logic          armed_q;
   logic          fire;

   assign fire = armed_q && pending;

   always_comb begin
      seen_nxt = seen_q;
      for (int i = 0; i < SW; i++) begin
         if (rd_stat && !armed_q && (rd_idx == IDX_W'(i))) seen_nxt[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         seen_q  <= '0;
         irq     <= 1'b0;
      end else begin
         irq <= fire;
         if (fire) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
         end else if (!armed_q && (&seen_nxt)) begin
            armed_q <= 1'b1;
            seen_q  <= '0;
         end else begin
            seen_q  <= seen_nxt;
         end
      end
   end
endmodule

// File: rtl/ring_evt_agg.sv
module ring_evt_agg #(
   parameter int N      = 12,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      tx_done_i,
   input  logic [N-1:0]      rx_done_i,
   input  logic [N-1:0]      rx_ovf_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);
   import ring_evt_pkg::*;

   localparam int SW       = words_for(3*N);
   localparam int EW       = words_for(2*N);
   localparam int SIDX_W   = idx_width(SW);
   localparam int EIDX_W   = idx_width(EW);
   localparam int ENA_BASE = 2**(ADDR_W-2);
   localparam int ID_ADDR  = 2**ADDR_W - 1;

   localparam logic [ADDR_W-1:0] SW_A   = ADDR_W'(SW);
   localparam logic [ADDR_W-1:0] EW_A   = ADDR_W'(EW);
   localparam logic [ADDR_W-1:0] ENA_LO = ADDR_W'(ENA_BASE);
   localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_ADDR);
   localparam logic [10:0]       HOPS   = 11'(N);

   // elaboration-time parameter checks
   if (N < 1 || N > 2047) begin : g_bad_n
      $error("ring_evt_agg: N must be in 1..2047");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("ring_evt_agg: ADDR_W too small");
   end
   if (SW > ENA_BASE) begin : g_bad_stat
      $error("ring_evt_agg: status words overlap enable region");
   end
   if (ENA_BASE + EW > ID_ADDR) begin : g_bad_ena
      $error("ring_evt_agg: enable words overlap identification word");
   end

   logic [SW*32-1:0]  stat_flat;
   logic [EW*32-1:0]  en_flat;
   logic [31:0]       stat_w [SW];
   logic [31:0]       en_w   [EW];

   logic              stat_sel, ena_sel, id_sel;
   logic [ADDR_W-1:0] e_off;
   logic [SIDX_W-1:0] s_idx;
   logic [EIDX_W-1:0] e_idx;
   logic              pending;

   // address decode: status from 0, enables from ENA_BASE, id at top
   assign e_off    = addr_i - ENA_LO;
   assign stat_sel = addr_i < SW_A;
   assign ena_sel  = (addr_i >= ENA_LO) && (e_off < EW_A);
   assign id_sel   = addr_i == ID_A;
   assign s_idx    = SIDX_W'(addr_i);
   assign e_idx    = EIDX_W'(e_off);

   ring_evt_store #(.N(N), .SW(SW), .IDX_W(SIDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_ev     (tx_done_i),
      .rx_ev     (rx_done_i),
      .ovf_ev    (rx_ovf_i),
      .clr_en    (rd_en_i && stat_sel),
      .clr_idx   (s_idx),
      .stat_flat (stat_flat)
   );

   ring_evt_mask #(.N(N), .EW(EW), .IDX_W(EIDX_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i && ena_sel),
      .wr_idx  (e_idx),
      .wdata   (wdata_i),
      .en_flat (en_flat)
   );

   for (genvar w = 0; w < SW; w++) begin : g_sw
      assign stat_w[w] = stat_flat[w*32 +: 32];
   end
   for (genvar w = 0; w < EW; w++) begin : g_ew
      assign en_w[w] = en_flat[w*32 +: 32];
   end

   // receive enable gates both receive and overflow bits
   always_comb begin
      pending = |(stat_flat[N-1:0]     & en_flat[2*N-1:N])
              | |(stat_flat[2*N-1:N]   & en_flat[N-1:0])
              | |(stat_flat[3*N-1:2*N] & en_flat[N-1:0]);
   end

   ring_evt_arm #(.SW(SW), .IDX_W(SIDX_W)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stat (rd_en_i && stat_sel),
      .rd_idx  (s_idx),
      .pending (pending),
      .irq     (irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (rd_en_i) begin
         if (stat_sel)      rdata_o <= stat_w[s_idx];
         else if (ena_sel)  rdata_o <= en_w[e_idx];
         else if (id_sel)   rdata_o <= {21'b0, HOPS};
         else               rdata_o <= '0;
      end
   end
endmodule

// File: rtl/ring_evt_chk.sv
module ring_evt_chk #(
   parameter int N      = 12,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rdata,
   input logic              irq,
   input logic [3*N-1:0]    stat_bits,
   input logic [2*N-1:0]    en_bits
);
   localparam int SW = ring_evt_pkg::words_for(3*N);
   localparam int EW = ring_evt_pkg::words_for(2*N);
   localparam logic [ADDR_W-1:0] SW_A     = ADDR_W'(SW);
   localparam logic [ADDR_W-1:0] ID_A     = ADDR_W'(2**ADDR_W - 1);
   localparam logic [ADDR_W-1:0] LAST_ENA = ADDR_W'(2**(ADDR_W-2) + EW - 1);
   localparam logic [31:0]       LAST_KEEP = ring_evt_pkg::valid_mask(2*N, EW-1);

   logic [SW-1:0] seen_c;
   logic          swept_c;
   logic          hit;

   assign hit = |(stat_bits[N-1:0]     & en_bits[2*N-1:N])
              | |(stat_bits[2*N-1:N]   & en_bits[N-1:0])
              | |(stat_bits[3*N-1:2*N] & en_bits[N-1:0]);

   // independent tracking of the read sweep from port activity
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_c  <= '0;
         swept_c <= 1'b1;
      end else if (irq) begin
         seen_c  <= '0;
         swept_c <= 1'b0;
      end else if (!swept_c) begin
         for (int i = 0; i < SW; i++) begin
            if (rd_en && addr < SW_A && addr == ADDR_W'(i)) seen_c[i] <= 1'b1;
         end
         if (&seen_c) swept_c <= 1'b1;
      end
   end

   assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(hit));

   assert_sweep_before_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (swept_c || (&seen_c)));

   assert_id_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ID_A) |=> (rdata == 32'(N)));

   assert_ena_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == LAST_ENA) |=> ((rdata & ~LAST_KEEP) == 32'h0));
endmodule

bind ring_evt_agg ring_evt_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en_i),
   .addr      (addr_i),
   .rdata     (rdata_o),
   .irq       (irq_o),
   .stat_bits (stat_flat[3*N-1:0]),
   .en_bits   (en_flat[2*N-1:0])
);

// File: tb/ring_evt_agg_tb_top.sv
`timescale 1ns/1ps
module ring_evt_agg_tb_top;
   localparam int N  = 12;
   localparam int AW = 6;
   localparam logic [AW-1:0] ENA_A = 6'd16;
   localparam logic [AW-1:0] ID_A  = 6'd63;

   // vector table: kind (0 tx,1 rx,2 ovf), hop, expected word, expected bit
   localparam int NV = 8;
   localparam int V_KIND [NV] = '{0, 0, 1, 1, 2, 2, 2, 2};
   localparam int V_HOP  [NV] = '{0, 11, 0, 11, 0, 7, 8, 11};
   localparam int V_WORD [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
   localparam int V_BIT  [NV] = '{0, 11, 12, 23, 24, 31, 0, 3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] tx = '0, rx = '0, ovf = '0;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic irq;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #2 clk = ~clk;

   ring_evt_agg #(.N(N), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_done_i(tx), .rx_done_i(rx), .rx_ovf_i(ovf),
      .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic set_ev(input int kind, input int hop);
      case (kind)
         0: tx[hop] = 1'b1;
         1: rx[hop] = 1'b1;
         default: ovf[hop] = 1'b1;
      endcase
   endtask

   task automatic pulse(input int kind, input int hop);
      @(negedge clk); set_ev(kind, hop);
      @(negedge clk); tx = '0; rx = '0; ovf = '0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      chk("R10 irq", 32'(irq), 32'h0);
      rd(6'd0, d);  chk("R10 status0", d, 32'h0);
      rd(6'd1, d);  chk("R10 status1", d, 32'h0);
      rd(ENA_A, d); chk("R10 enable", d, 32'h0);

      // R1 / R2: table walk of bit packing and clear-on-read
      for (int i = 0; i < NV; i++) begin
         pulse(V_KIND[i], V_HOP[i]);
         rd(6'(V_WORD[i]), d);
         chk("R1 packing", d, 32'h1 << V_BIT[i]);
         rd(6'(V_WORD[i]), d);
         chk("R2 cleared", d, 32'h0);
      end

      // R3: event on the same cycle as the clearing read
      pulse(0, 0);
      @(negedge clk); rd_en = 1'b1; addr = 6'd0; tx[2] = 1'b1;
      @(negedge clk); rd_en = 1'b0; tx = '0; d = rdata;
      chk("R3 old contents", d, 32'h1);
      rd(6'd0, d); chk("R3 event kept", d, 32'h4);

      // R4: enable storage and padding
      wr(ENA_A, 32'hFFFF_FFFF);
      rd(ENA_A, d); chk("R4 enable readback", d, 32'h00FF_FFFF);
      wr(ENA_A, 32'h0);
      rd(ENA_A, d); chk("R4 enable cleared", d, 32'h0);

      // R5: identification and unmapped addresses
      rd(ID_A, d); chk("R5 id", d, 32'd12);
      wr(ID_A, 32'h0000_0ABC);
      rd(ID_A, d); chk("R5 id after write", d, 32'd12);
      rd(6'd5, d); chk("R5 unmapped", d, 32'h0);

      // R7: disabled ring latches but stays quiet; R6: enabled ring fires once
      wr(ENA_A, 32'h0000_1000);          // transmit enable hop 0
      pulse(0, 4); settle();
      chk("R7 no irq from disabled", 32'(irq_cnt), 32'd0);
      pulse(0, 0); settle();
      chk("R6 single pulse", 32'(irq_cnt), 32'd1);

      // R9: partial sweep keeps interrupt held off
      rd(6'd0, d); chk("R7 disabled bit latched", d, 32'h11);
      pulse(0, 0); settle();
      chk("R9 held after one word", 32'(irq_cnt), 32'd1);
      rd(6'd0, d); chk("R9 bit latched while disarmed", d, 32'h1);
      pulse(0, 0); settle();
      chk("R9 still held", 32'(irq_cnt), 32'd1);
      rd(6'd1, d); chk("R9 disabled-only word", d, 32'h0);
      settle();
      chk("R9 refire after sweep", 32'(irq_cnt), 32'd2);

      // R8: overflow gated by receive enable
      rd(6'd0, d);
      rd(6'd1, d);
      settle();
      chk("R9 clean rearm", 32'(irq_cnt), 32'd2);
      wr(ENA_A, 32'h0000_0008);          // receive enable hop 3
      pulse(2, 5); settle();
      chk("R8 overflow hop5 quiet", 32'(irq_cnt), 32'd2);
      pulse(2, 3); settle();
      chk("R8 overflow hop3 fires", 32'(irq_cnt), 32'd3);
      rd(6'd0, d); chk("R8 overflow latched", d, 32'h2800_0000);

      finish_run();
   end
endmodule